// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter

This block decides whether a received frame is kept, based on its 11-bit identifier. A host programs two 8-bit registers: a match pattern and a don't-care mask. Only the upper eight identifier bits (bits 10 down to 3) are compared with the pattern. Any position whose mask bit is 1 matches whatever value the identifier has there.

The host can read and write the two registers only while the controller is held in its configuration (reset) mode. Outside that mode, writes leave the registers unchanged and reads return zero. The receive path pulses a strobe when the identifier field is complete. On that strobe the filter evaluates the identifier and latches an accept flag, which holds its value until the next strobe.

Top module: `id_accept_filter`

## Requirements
- R1: While `cfg_mode` is 1, a write to offset 0x04 stores `host_wdata` as the match pattern, and a write to offset 0x05 stores it as the mask. A read of either offset with `host_rd` high returns the stored value on `host_rdata` in the same cycle.
- R2: A frame is accepted (`accept` = 1) when, for every i from 0 to 7, `id_bits[i+3]` equals pattern bit i or mask bit i is 1.
- R3: A frame is rejected (`accept` = 0) when at least one unmasked position differs from the pattern.
- R4: When `cfg_mode` is 0, host writes to either register are ignored and the stored values are kept.
- R5: When `cfg_mode` is 0, `host_rdata` is 0x00 for every read.
- R6: `accept` takes the new decision in the cycle after `id_done` is high. It holds that value while `id_done` stays low, even if `id_bits` changes.
- R7: After synchronous reset, both registers read 0xFF and `accept` is 0. The first strobe after reset accepts any identifier.
- R8: `id_bits[2:0]` never affect the decision.
- R9: Writes to any offset other than 0x04 and 0x05 change neither register, and reads of such offsets return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | 1 while the controller is in configuration (reset) mode |
| host_wr | input | 1 | Host write enable |
| host_rd | input | 1 | Host read enable |
| host_addr | input | 5 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| id_bits | input | 11 | Received identifier |
| id_done | input | 1 | Strobe marking the end of the identifier field |
| accept | output | 1 | Latched accept decision |

## Verification
The hardest case to reach is an ignored write: its only trace is a value that did not change. The stimulus therefore first stores a known pattern and mask in configuration mode. It then drops the mode and writes different values. Finally it returns to configuration mode to read the registers back, and also runs identifiers whose decision would differ if the ignored write had taken effect. Holding the decision is tested by changing `id_bits` between strobes and sampling `accept` each cycle.

// File: rtl/acf_pkg.sv
package acf_pkg;

    localparam int ACF_ADDR_W = 5;
    localparam int ACF_ID_W   = 11;
    localparam int ACF_CMP_W  = 8;
    localparam int ACF_CMP_LSB = ACF_ID_W - ACF_CMP_W;

    localparam logic [ACF_ADDR_W-1:0] ACF_OFS_CODE = 5'h04;
    localparam logic [ACF_ADDR_W-1:0] ACF_OFS_MASK = 5'h05;

    localparam logic [ACF_CMP_W-1:0] ACF_RST_VAL = '1;

    typedef logic [ACF_CMP_W-1:0] acf_byte_t;

    typedef struct packed {
        acf_byte_t pattern;
        acf_byte_t dontcare;
    } acf_cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CODE = 2'd1,
        SEL_MASK = 2'd2
    } acf_sel_e;

    function automatic acf_sel_e acf_decode(input logic [ACF_ADDR_W-1:0] a);
        if (a == ACF_OFS_CODE)      return SEL_CODE;
        else if (a == ACF_OFS_MASK) return SEL_MASK;
        else                        return SEL_NONE;
    endfunction

endpackage

// File: rtl/acf_regs.sv
module acf_regs
    import acf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_mode,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [ACF_ADDR_W-1:0] addr,
    input  acf_byte_t             wdata,
    output acf_byte_t             rdata,
    output acf_cfg_t              cfg
);

    acf_cfg_t cfg_q;
    acf_sel_e sel;

    assign sel = acf_decode(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pattern  <= ACF_RST_VAL;
            cfg_q.dontcare <= ACF_RST_VAL;
        end else if (wr && cfg_mode) begin
            case (sel)
                SEL_CODE: cfg_q.pattern  <= wdata;
                SEL_MASK: cfg_q.dontcare <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (rd && cfg_mode) begin
            case (sel)
                SEL_CODE: rdata = cfg_q.pattern;
                SEL_MASK: rdata = cfg_q.dontcare;
                default:  rdata = '0;
            endcase
        end
    end

    assign cfg = cfg_q;

    AST_RUN_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(cfg_q)); // R4

    AST_CODE_WRITE_STORES: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode && wr && addr == ACF_OFS_CODE) |=> cfg_q.pattern == $past(wdata)); // R1

    AST_OTHER_ADDR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (addr != ACF_OFS_CODE && addr != ACF_OFS_MASK) |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/acf_compare.sv
module acf_compare
    import acf_pkg::*;
(
    input  logic [ACF_ID_W-1:0] id,
    input  acf_cfg_t            cfg,
    output logic                match
);

    logic [ACF_CMP_W-1:0] bit_ok;
    logic                 unused_id_low;

    assign unused_id_low = ^id[ACF_CMP_LSB-1:0];

    for (genvar i = 0; i < ACF_CMP_W; i++) begin : g_bit
        assign bit_ok[i] = (id[i+ACF_CMP_LSB] == cfg.pattern[i]) | cfg.dontcare[i];
    end

    assign match = &bit_ok;

endmodule

// File: rtl/acf_decision.sv
module acf_decision (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic match,
    output logic accept
);

    logic accept_q;

    always_ff @(posedge clk) begin
        if (rst)       accept_q <= 1'b0;
        else if (done) accept_q <= match;
    end

    assign accept = accept_q;

    AST_DECISION_LATCH: assert property (@(posedge clk) disable iff (rst)
        done |=> accept_q == $past(match)); // R6

    AST_DECISION_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(accept_q)); // R6

endmodule

// File: rtl/id_accept_filter.sv
module id_accept_filter
    import acf_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_mode,
    input  logic                  host_wr,
    input  logic                  host_rd,
    input  logic [ACF_ADDR_W-1:0] host_addr,
    input  logic [ACF_CMP_W-1:0]  host_wdata,
    output logic [ACF_CMP_W-1:0]  host_rdata,
    input  logic [ACF_ID_W-1:0]   id_bits,
    input  logic                  id_done,
    output logic                  accept
);

    acf_cfg_t cfg;
    logic     match;

    acf_regs i_regs (
        .clk      (clk),
        .rst      (rst),
        .cfg_mode (cfg_mode),
        .wr       (host_wr),
        .rd       (host_rd),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .cfg      (cfg)
    );

    acf_compare i_cmp (
        .id    (id_bits),
        .cfg   (cfg),
        .match (match)
    );

    acf_decision i_dec (
        .clk    (clk),
        .rst    (rst),
        .done   (id_done),
        .match  (match),
        .accept (accept)
    );

    AST_FULL_MASK_ACCEPTS: assert property (@(posedge clk) disable iff (rst)
        (id_done && cfg.dontcare == '1) |=> accept); // R2

    AST_RUN_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |-> host_rdata == '0); // R5

endmodule

// File: tb/test_id_accept_filter.sv
module test_id_accept_filter;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_mode;
    logic        host_wr;
    logic        host_rd;
    logic [4:0]  host_addr;
    logic [7:0]  host_wdata;
    logic [7:0]  host_rdata;
    logic [10:0] id_bits;
    logic        id_done;
    logic        accept;

    int checks = 0;
    int failures = 0;

    logic [7:0] m_code;
    logic [7:0] m_mask;

    always #(CLK_PERIOD/2) clk = ~clk;

    id_accept_filter i_id_accept_filter (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .id_bits(id_bits), .id_done(id_done),
        .accept(accept)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model(input logic [10:0] id);
        return &(~(id[10:3] ^ m_code) | m_mask);
    endfunction

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        if (cfg_mode) begin
            if (a == 5'h04) m_code = d;
            if (a == 5'h05) m_mask = d;
        end
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic decide(input logic [10:0] id, input string req);
        @(negedge clk);
        id_bits = id; id_done = 1'b1;
        @(negedge clk);
        id_done = 1'b0;
        chk(req, {7'd0, accept}, {7'd0, model(id)});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R7 accept after reset", {7'd0, accept}, 8'h00);
        rd_reg(5'h04, v); chk("R7 code reset", v, 8'hFF);
        rd_reg(5'h05, v); chk("R7 mask reset", v, 8'hFF);
        decide(11'h2A5, "R7 first strobe accepts");
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        wr_reg(5'h04, 8'hA5);
        wr_reg(5'h05, 8'h00);
        rd_reg(5'h04, v); chk("R1 code readback", v, 8'hA5);
        rd_reg(5'h05, v); chk("R1 mask readback", v, 8'h00);
    endtask

    task automatic t_compare;
        decide({8'hA5, 3'b000}, "R2 exact match");
        decide({8'hA4, 3'b000}, "R3 bit0 differs");
        decide({8'h25, 3'b000}, "R3 bit7 differs");
        wr_reg(5'h05, 8'h81);
        decide({8'h24, 3'b000}, "R2 masked edges");
        decide({8'hA7, 3'b000}, "R3 unmasked bit1");
        for (int k = 0; k < 24; k++) begin
            logic [10:0] id = 11'((k * 173 + 61) % 2048);
            decide(id, "R2 R3 sweep");
        end
    endtask

    task automatic t_low_bits;
        wr_reg(5'h05, 8'h00);
        for (int k = 0; k < 8; k++) decide({8'hA5, 3'(k)}, "R8 low bits match");
        for (int k = 0; k < 8; k++) decide({8'h5A, 3'(k)}, "R8 low bits miss");
    endtask

    task automatic t_hold;
        decide({8'hA5, 3'b000}, "R6 latch accept");
        @(negedge clk); id_bits = {8'h00, 3'b111};
        @(negedge clk); chk("R6 hold high", {7'd0, accept}, 8'h01);
        decide({8'h5A, 3'b000}, "R6 latch reject");
        @(negedge clk); id_bits = {8'hA5, 3'b000};
        @(negedge clk); chk("R6 hold low", {7'd0, accept}, 8'h00);
    endtask

    task automatic t_run_mode;
        logic [7:0] v;
        @(negedge clk); cfg_mode = 1'b0;
        wr_reg(5'h04, 8'h3C);
        wr_reg(5'h05, 8'hFF);
        rd_reg(5'h04, v); chk("R5 run read code", v, 8'h00);
        rd_reg(5'h05, v); chk("R5 run read mask", v, 8'h00);
        decide({8'h3C, 3'b000}, "R4 ignored write rejects");
        decide({8'hA5, 3'b010}, "R4 old pattern kept");
        @(negedge clk); cfg_mode = 1'b1;
        rd_reg(5'h04, v); chk("R4 code kept", v, 8'hA5);
        rd_reg(5'h05, v); chk("R4 mask kept", v, 8'h00);
    endtask

    task automatic t_other_addr;
        logic [7:0] v;
        wr_reg(5'h06, 8'h11);
        wr_reg(5'h03, 8'h22);
        wr_reg(5'h1F, 8'h33);
        rd_reg(5'h04, v); chk("R9 code untouched", v, 8'hA5);
        rd_reg(5'h05, v); chk("R9 mask untouched", v, 8'h00);
        rd_reg(5'h06, v); chk("R9 other read zero", v, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_mode = 1'b1; host_wr = 1'b0; host_rd = 1'b0;
        host_addr = '0; host_wdata = '0; id_bits = '0; id_done = 1'b0;
        m_code = 8'hFF; m_mask = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_write_read;
        t_compare;
        t_low_bits;
        t_hold;
        t_run_mode;
        t_other_addr;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule